// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits behind the byte-wide register port of a programmable interrupt controller. It decodes I/O writes to the controller's two ports, an even (base) port and an odd (base+1) port. It tracks the fixed four-byte initialization sequence and holds the configuration that the interrupt core reads: vector base, cascade identity, trigger mode, automatic end-of-interrupt enable, mask register, special-mask flag and status-read select.

A write to the even port with data bit 4 set is always taken as the first initialization word. It restarts the sequence from whatever state the block is in and loads a defined set of defaults at once. The next three odd-port writes are taken as words 2, 3 and 4. Only after the fourth word do odd-port writes reach the mask register. When the first word is taken, the block pulses a clear to the core so that edge-mode requests must make a fresh low-to-high transition before they can raise an interrupt.

The control path is a four-state machine:
- `ST_READY`: configured, and after reset.
- `ST_WAIT_W2`, `ST_WAIT_W3`, `ST_WAIT_W4`: waiting for word 2, 3 or 4.

Its transitions are:
- `START`: any state to `ST_WAIT_W2`, on a first-word write.
- `TAKE_W2`: `ST_WAIT_W2` to `ST_WAIT_W3`, on an odd write.
- `TAKE_W3`: `ST_WAIT_W3` to `ST_WAIT_W4`, on an odd write.
- `FINISH`: `ST_WAIT_W4` to `ST_READY`, on an odd write.
- `MASK_LOAD`: `ST_READY` to `ST_READY`, on an odd write.

Every other write leaves the state where it is.

Top module: `pic_init_seq`

## Requirements
- R1: An even-port write with data bit 4 = 1 moves the block to `ST_WAIT_W2` from any state. `init_busy` is 1 from the next cycle.
- R2: After the first word, the next three odd-port writes are taken in order as words 2, 3 and 4. `init_busy` stays 1 until the fourth is accepted and is 0 from the cycle after it.
- R3: First-word data bit 3 sets `level_mode`: 1 selects level mode and 0 selects edge mode.
- R4: Word 2 bits 7:3 load `vec_base`, word 3 bits 2:0 load `slave_id`, and word 4 bit 1 loads `auto_eoi`.
- R5: A first-word write clears `mask` to 8'h00.
- R6: A first-word write sets `slave_id` to 7, clears `special_mask`, sets `read_isr` to 0 (status reads return the request register) and clears `auto_eoi`.
- R7: `edge_clear` is 1 for exactly the one cycle after each first-word write and 0 otherwise.
- R8: Odd-port writes during the sequence never load `mask`. In `ST_READY` an odd-port write loads `mask` with the data byte.
- R9: Even-port writes with bit 4 = 0 change no state, with one exception. In `ST_READY`, a write with bit 3 = 1 is a read/mask command:
  - bit 1 = 1 loads `read_isr` from bit 0;
  - bit 6 = 1 loads `special_mask` from bit 5.
  During the sequence these writes are ignored.
- R10: After reset the outputs are `init_busy` 0, `mask` 8'hFF, `slave_id` 7, `vec_base` 0, and `level_mode`, `auto_eoi`, `special_mask`, `read_isr` and `edge_clear` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| port_odd | input | 1 | 0 selects the even port, 1 selects the odd port |
| wr_data | input | 8 | Write data byte |
| init_busy | output | 1 | Initialization sequence in progress |
| vec_base | output | 5 | Interrupt vector base, bits 7:3 |
| slave_id | output | 3 | Cascade / slave identity |
| level_mode | output | 1 | 1 = level-triggered requests |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| mask | output | 8 | Interrupt mask register |
| special_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Status read select, 0 = request register, 1 = in-service register |
| edge_clear | output | 1 | One-cycle pulse: reset edge detectors in the core |

## Verification
The assertions check the following on every cycle:
- a first-word write always restarts the sequence, clears the mask and loads the defaults;
- `edge_clear` never pulses without a first-word write one cycle earlier;
- `init_busy` only falls after an odd-port write;
- odd-port writes during the sequence leave the mask untouched.

Other behaviour can only be shown by the bench's scenarios:
- that the three words land in the right fields in the right order;
- that a restart in mid-sequence makes the next odd write word 2 again;
- that ignored even-port writes really leave every field as it was.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_WAIT_W2 = 2'd1,
        ST_WAIT_W3 = 2'd2,
        ST_WAIT_W4 = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic start;     // first initialization word
        logic odd_wr;    // any write to the odd port
        logic rd_cmd;    // even-port read/mask command
    } wr_kind_t;

endpackage

// File: rtl/pic_init_decode.sv
module pic_init_decode
    import pic_init_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int START_BIT = 4,
    parameter int CMD_BIT   = 3
) (
    input  logic              wr_en,
    input  logic              port_odd,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_t          kind
);

    always_comb begin
        kind        = '0;
        kind.odd_wr = wr_en && port_odd;
        kind.start  = wr_en && !port_odd && wr_data[START_BIT];
        kind.rd_cmd = wr_en && !port_odd && !wr_data[START_BIT] && wr_data[CMD_BIT];
    end

endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wr_kind_t   kind,
    output seq_state_t state,
    output logic       busy
);

    seq_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (kind.start) begin
            state_nx = ST_WAIT_W2;                 // START
        end else if (kind.odd_wr) begin
            unique case (state)
                ST_WAIT_W2: state_nx = ST_WAIT_W3; // TAKE_W2
                ST_WAIT_W3: state_nx = ST_WAIT_W4; // TAKE_W3
                ST_WAIT_W4: state_nx = ST_READY;   // FINISH
                ST_READY:   state_nx = ST_READY;   // MASK_LOAD
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state != ST_READY);
    end

endmodule

// File: rtl/pic_init_cfg.sv
module pic_init_cfg
    import pic_init_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_IRQ  = 8,
    parameter int LVL_BIT  = 3,
    parameter int AEOI_BIT = 1,
    parameter int RSEL_EN  = 1,
    parameter int RSEL_VAL = 0,
    parameter int SMM_EN   = 6,
    parameter int SMM_VAL  = 5,
    localparam int ID_W    = $clog2(NUM_IRQ),
    localparam int VEC_W   = DATA_W - ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_t          kind,
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VEC_W-1:0]  vec_base,
    output logic [ID_W-1:0]   slave_id,
    output logic              level_mode,
    output logic              auto_eoi,
    output logic [DATA_W-1:0] mask,
    output logic              special_mask,
    output logic              read_isr,
    output logic              edge_clear
);

    localparam logic [ID_W-1:0] ID_DEFAULT = ID_W'(NUM_IRQ - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base     <= '0;
            slave_id     <= ID_DEFAULT;
            level_mode   <= 1'b0;
            auto_eoi     <= 1'b0;
            mask         <= '1;
            special_mask <= 1'b0;
            read_isr     <= 1'b0;
            edge_clear   <= 1'b0;
        end else begin
            edge_clear <= kind.start;
            if (kind.start) begin
                mask         <= '0;
                slave_id     <= ID_DEFAULT;
                special_mask <= 1'b0;
                read_isr     <= 1'b0;
                auto_eoi     <= 1'b0;
                level_mode   <= wr_data[LVL_BIT];
            end else if (kind.odd_wr) begin
                unique case (state)
                    ST_WAIT_W2: vec_base <= wr_data[DATA_W-1:ID_W];
                    ST_WAIT_W3: slave_id <= wr_data[ID_W-1:0];
                    ST_WAIT_W4: auto_eoi <= wr_data[AEOI_BIT];
                    ST_READY:   mask     <= wr_data;
                endcase
            end else if (kind.rd_cmd && state == ST_READY) begin
                if (wr_data[RSEL_EN]) read_isr     <= wr_data[RSEL_VAL];
                if (wr_data[SMM_EN])  special_mask <= wr_data[SMM_VAL];
            end
        end
    end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_init_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_IRQ = 8,
    localparam int ID_W   = $clog2(NUM_IRQ),
    localparam int VEC_W  = DATA_W - ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              port_odd,
    input  logic [DATA_W-1:0] wr_data,
    output logic              init_busy,
    output logic [VEC_W-1:0]  vec_base,
    output logic [ID_W-1:0]   slave_id,
    output logic              level_mode,
    output logic              auto_eoi,
    output logic [DATA_W-1:0] mask,
    output logic              special_mask,
    output logic              read_isr,
    output logic              edge_clear
);

    wr_kind_t   kind;
    seq_state_t state;

    pic_init_decode #(.DATA_W(DATA_W)) u_decode (
        .wr_en    (wr_en),
        .port_odd (port_odd),
        .wr_data  (wr_data),
        .kind     (kind)
    );

    pic_init_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .state (state),
        .busy  (init_busy)
    );

    pic_init_cfg #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .state        (state),
        .wr_data      (wr_data),
        .vec_base     (vec_base),
        .slave_id     (slave_id),
        .level_mode   (level_mode),
        .auto_eoi     (auto_eoi),
        .mask         (mask),
        .special_mask (special_mask),
        .read_isr     (read_isr),
        .edge_clear   (edge_clear)
    );

endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
    parameter int DATA_W  = 8,
    parameter int ID_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              port_odd,
    input logic [DATA_W-1:0] wr_data,
    input logic              init_busy,
    input logic [ID_W-1:0]   slave_id,
    input logic [DATA_W-1:0] mask,
    input logic              special_mask,
    input logic              read_isr,
    input logic              edge_clear
);

    logic first_wr;
    assign first_wr = wr_en && !port_odd && wr_data[4];

    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> init_busy);

    assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> (mask == '0));

    assert_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> (slave_id == '1 && !special_mask && !read_isr));

    assert_pulse_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_clear |-> $past(first_wr));

    assert_pulse_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> edge_clear);

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy) |-> $past(wr_en && port_odd));

    assert_no_mask_in_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && wr_en && port_odd) |=> $stable(mask));

endmodule

bind pic_init_seq pic_init_seq_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .port_odd     (port_odd),
    .wr_data      (wr_data),
    .init_busy    (init_busy),
    .slave_id     (slave_id),
    .mask         (mask),
    .special_mask (special_mask),
    .read_isr     (read_isr),
    .edge_clear   (edge_clear)
);

// File: tb/pic_init_seq_tb.sv
module pic_init_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       port_odd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       init_busy, level_mode, auto_eoi, special_mask, read_isr, edge_clear;
    logic [4:0] vec_base;
    logic [2:0] slave_id;
    logic [7:0] mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pic_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_odd(port_odd),
        .wr_data(wr_data), .init_busy(init_busy), .vec_base(vec_base),
        .slave_id(slave_id), .level_mode(level_mode), .auto_eoi(auto_eoi),
        .mask(mask), .special_mask(special_mask), .read_isr(read_isr),
        .edge_clear(edge_clear)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-cycle write; outputs are sampled 1 ns after the capturing edge
    task automatic wr(input logic odd, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_odd = odd; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    task automatic full_init(input logic lvl, input logic [4:0] vb,
                             input logic [2:0] sid, input logic ae);
        wr(1'b0, 8'h10 | {4'b0, lvl, 3'b0});
        check("R1 busy after word1", init_busy, 1);
        check("R7 pulse after word1", edge_clear, 1);
        check("R5 mask cleared", mask, 8'h00);
        check("R6 slave id default", slave_id, 7);
        check("R3 level bit", level_mode, lvl);
        wr(1'b1, {vb, 3'b000});
        check("R7 pulse one cycle", edge_clear, 0);
        check("R2 busy after word2", init_busy, 1);
        check("R4 vector base", vec_base, vb);
        wr(1'b1, {5'b0, sid});
        check("R2 busy after word3", init_busy, 1);
        check("R8 mask held in seq", mask, 8'h00);
        wr(1'b1, {6'b0, ae, 1'b0});
        check("R2 idle after word4", init_busy, 0);
        check("R4 slave id", slave_id, sid);
        check("R4 auto eoi", auto_eoi, ae);
        check("R8 mask held after word4", mask, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 busy", init_busy, 0);
        check("R10 mask", mask, 8'hFF);
        check("R10 slave id", slave_id, 7);
        check("R10 vec base", vec_base, 0);
        check("R10 flags", {level_mode, auto_eoi, special_mask, read_isr, edge_clear}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // sweep every vector base with varied fields
        for (int v = 0; v < 32; v++) begin
            full_init(v[0], v[4:0], v[2:0] ^ 3'd5, v[1]);
            for (int m = 0; m < 4; m++) begin
                logic [7:0] mv;
                mv = 8'(v * 37 + m * 91);
                wr(1'b1, mv);
                check("R8 mask load when ready", mask, mv);
                check("R8 busy stays low", init_busy, 0);
            end
        end

        // R9 read/mask command in ready state
        wr(1'b0, 8'h0B);
        check("R9 read select set", read_isr, 1);
        wr(1'b0, 8'h68);
        check("R9 special mask set", special_mask, 1);
        wr(1'b0, 8'h0A);
        check("R9 read select clear", read_isr, 0);
        wr(1'b0, 8'h0B);
        // R9 even writes with bits 4 and 3 clear change nothing
        wr(1'b1, 8'hA5);
        for (int d = 0; d < 256; d++) begin
            logic [7:0] b;
            b = 8'(d);
            if (!b[4] && !b[3]) begin
                wr(1'b0, b);
                check("R9 ignored write mask", mask, 8'hA5);
                check("R9 ignored write flags",
                      {init_busy, special_mask, read_isr, edge_clear}, 4'b0110);
            end
        end

        // R6 first word resets special mask and read select
        wr(1'b0, 8'h18);
        check("R6 special mask cleared", special_mask, 0);
        check("R6 read select IRR", read_isr, 0);
        check("R6 auto eoi cleared", auto_eoi, 0);
        check("R3 level mode set", level_mode, 1);
        // R9 read command ignored during sequence
        wr(1'b0, 8'h0B);
        check("R9 command ignored in seq", read_isr, 0);
        check("R1 still busy", init_busy, 1);

        // R1 restart in mid-sequence
        wr(1'b1, 8'hC8);
        check("R4 vec base word2", vec_base, 5'h19);
        wr(1'b0, 8'h10);
        check("R1 restart busy", init_busy, 1);
        check("R3 edge mode", level_mode, 0);
        check("R7 restart pulse", edge_clear, 1);
        wr(1'b1, 8'h38);
        check("R1 next odd is word2", vec_base, 5'h07);
        wr(1'b1, 8'h02);
        check("R1 next odd is word3", slave_id, 2);
        idle();
        check("R7 no pulse idle", edge_clear, 0);
        wr(1'b1, 8'h02);
        check("R2 done after restart", init_busy, 0);
        check("R4 aeoi set", auto_eoi, 1);
        check("R8 mask still clear", mask, 8'h00);

        // R1 restart from waiting for word 4
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h10);
        check("R1 restart from word4 wait", init_busy, 1);
        wr(1'b1, 8'hF8);
        check("R1 word2 after late restart", vec_base, 5'h1F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule